// File: doc/BRIEF.md
# Debug ROM Table Walker

This block discovers debug components that sit behind a memory access port. Given the value of the port's base register, it reads the identification words of the top-level ROM table. If they are valid, it reads the table's entries one after another. Each present entry yields a component base address. The walker reads that component's identification block and emits one record for it. When the component is itself a classic ROM table, the walker descends into it, and afterwards resumes the parent at the entry that follows.

All traffic leaves on a simple memory port that carries 32-bit reads, with only one read in flight at a time. A request is held until it is accepted. Its response may come back on any later cycle, and it carries an error flag. Records leave on a valid/ready stream, and a stalled consumer stalls the walk. Nested tables are tracked on a bounded return stack. The walker keeps running when that stack would overflow. It flags the overflow instead of descending further.

Top module: `romwalk_top`

## Requirements
- R1: A start whose base value does not have both bit 0 (present) and bit 1 (format) set, for example 0x00000002, finishes with `no_table` high, issues no memory read and emits no record.
- R2: The identification block of a table or component is read as twelve words at page offsets 0xFD0 to 0xFFC. Words 0 to 3 are PID4 to PID7, words 4 to 7 are PID0 to PID3 and words 8 to 11 are CID0 to CID3, with the low byte of each word used. The ID is valid when CID0=0x0D, CID2=0x05 and CID3=0xB1. A root table with an invalid ID ends the walk with `no_table` high and no records.
- R3: Entries of a table are read at table base plus 4*i for i = 0, 1, 2, and so on. An entry equal to 0x00000000 ends that table.
- R4: An entry counts as present only when its bits [1:0] are 2'b11. Other non-zero entries are skipped with no read of the address they point to.
- R5: A component's base is the table base plus entry bits [31:12], taken as a signed 20-bit count of 4 KB pages. For example, entry 0xFFFFF003 in the table at 0x80030000 gives 0x8002F000.
- R6: Each present entry produces one record. The record carries `rec_base`, `rec_class` = CID1[7:4], `rec_pid` = {PID7,...,PID0} with PID0 in bits [7:0], and `rec_id_ok`.
- R7: A component with a valid ID and class 0x1 is walked as a nested table after its record is accepted. The parent then resumes at the next entry.
- R8: When a nested table is found while DEPTH frames are already stacked, `stack_err` is set. The record is still emitted, the table is not entered, and the walk continues.
- R9: At most MAX_ENTRIES (default 960) entries are read per table. Entry index MAX_ENTRIES is never read.
- R10: If any response to a component's ID reads carries an error, the record has `rec_unreadable`=1. An entry read that returns an error is skipped.
- R11: While `rec_valid` is high and `rec_ready` is low, the record fields stay unchanged and the walk does not advance.
- R12: `req_valid` and `req_addr` stay unchanged until `req_ready` is seen.
- R13: `done` pulses for one cycle when a walk ends. `no_table` and `stack_err` hold until the next accepted start. A start while `busy` is high is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Begin a walk with `base_in` |
| base_in | input | 32 | Base register value: page in [31:12], format bit 1, present bit 0 |
| busy | output | 1 | Walk in progress |
| done | output | 1 | One-cycle pulse at the end of a walk |
| no_table | output | 1 | Base not present or root ID invalid |
| stack_err | output | 1 | Nesting deeper than DEPTH was seen |
| req_valid | output | 1 | Read request valid |
| req_ready | input | 1 | Read request accepted |
| req_addr | output | 32 | Read word address |
| resp_valid | input | 1 | Read response valid |
| resp_data | input | 32 | Read data |
| resp_err | input | 1 | Read response error |
| rec_valid | output | 1 | Record valid |
| rec_ready | input | 1 | Record accepted |
| rec_base | output | 32 | Component base address |
| rec_class | output | 4 | Component class |
| rec_pid | output | 64 | Peripheral ID bytes PID7..PID0 |
| rec_id_ok | output | 1 | Component ID preamble valid |
| rec_unreadable | output | 1 | An ID read of this component failed |

## Verification
The assertions assume that the memory side sends exactly one response for each accepted request. They also assume that no response arrives while no read is outstanding. The bench memory model answers one cycle after acceptance and stalls acceptance on a fixed cycle pattern, so both hold. Record back-pressure comes from another repeating pattern, which exercises the hold rules on both streams. The memory image is built so that nesting, skipped entries, negative offsets, error responses, the stack limit and the entry limit each appear at least once.

// File: rtl/romwalk_pkg.sv
package romwalk_pkg;
  localparam logic [7:0] CID0_VAL = 8'h0D;
  localparam logic [7:0] CID2_VAL = 8'h05;
  localparam logic [7:0] CID3_VAL = 8'hB1;
  localparam logic [3:0] CLASS_TABLE = 4'h1;
  localparam int ID_WORDS = 12;
  localparam logic [11:0] ID_OFFSET = 12'hFD0;

  typedef enum logic [2:0] {
    S_IDLE, S_ROOT, S_ENT_REQ, S_ENT_WAIT, S_COMP, S_EMIT, S_POP, S_FINISH
  } walk_state_t;

  typedef enum logic [1:0] {F_IDLE, F_REQ, F_WAIT} fetch_state_t;

  function automatic logic entry_present(input logic [31:0] e);
    return e[1:0] == 2'b11;
  endfunction
endpackage

// File: rtl/romwalk_idfetch.sv
module romwalk_idfetch
  import romwalk_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        go,
  input  logic [19:0] page,
  output logic        req_valid,
  input  logic        req_ready,
  output logic [31:0] req_addr,
  input  logic        resp_valid,
  input  logic [7:0]  resp_byte,
  input  logic        resp_err,
  output logic        done,
  output logic [63:0] pid,
  output logic [3:0]  cls,
  output logic        id_ok,
  output logic        err
);
  fetch_state_t st;
  logic [3:0]  cnt;
  logic [31:0] cid_q;

  assign req_valid = (st == F_REQ);
  assign req_addr  = {page, ID_OFFSET + {6'd0, cnt, 2'b00}};
  assign cls   = cid_q[15:12];
  assign id_ok = (cid_q[7:0] == CID0_VAL) && (cid_q[23:16] == CID2_VAL) &&
                 (cid_q[31:24] == CID3_VAL);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= F_IDLE; cnt <= '0; cid_q <= '0; pid <= '0; err <= 1'b0; done <= 1'b0;
    end else begin
      done <= 1'b0;
      case (st)
        F_IDLE: if (go) begin
          st <= F_REQ; cnt <= '0; err <= 1'b0; cid_q <= '0; pid <= '0;
        end
        F_REQ: if (req_ready) st <= F_WAIT;
        F_WAIT: if (resp_valid) begin
          err <= err | resp_err;
          if (cnt < 4'd4)      pid[8*(int'(cnt)+4) +: 8] <= resp_byte;
          else if (cnt < 4'd8) pid[8*(int'(cnt)-4) +: 8] <= resp_byte;
          else                 cid_q[8*(int'(cnt)-8) +: 8] <= resp_byte;
          if (cnt == 4'(ID_WORDS-1)) begin
            st <= F_IDLE; done <= 1'b1;
          end else begin
            cnt <= cnt + 4'd1; st <= F_REQ;
          end
        end
        default: st <= F_IDLE;
      endcase
    end
  end

  a_r12_id_req_hold: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && !req_ready |=> req_valid && $stable(req_addr));
  a_r2_resp_only_waiting: assert property (@(posedge clk) disable iff (!rst_n)
    (st == F_WAIT) && resp_valid |-> cnt < 4'(ID_WORDS));
endmodule

// File: rtl/romwalk_stack.sv
module romwalk_stack #(
  parameter int DEPTH = 4,
  parameter int WIDTH = 30
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             push,
  input  logic             pop,
  input  logic [WIDTH-1:0] push_data,
  output logic [WIDTH-1:0] top_data,
  output logic             empty,
  output logic             full
);
  localparam int CW = $clog2(DEPTH + 1);
  logic [CW-1:0] count;
  logic [WIDTH-1:0] slot [DEPTH];

  assign empty = (count == '0);
  assign full  = (count == CW'(DEPTH));
  assign top_data = empty ? '0 : slot[count - CW'(1)];

  for (genvar g = 0; g < DEPTH; g++) begin : g_slot
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) slot[g] <= '0;
      else if (push && count == CW'(g)) slot[g] <= push_data;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) count <= '0;
    else if (push && !full) count <= count + CW'(1);
    else if (pop && !empty) count <= count - CW'(1);
  end

  a_r8_no_push_full: assert property (@(posedge clk) disable iff (!rst_n)
    push |-> !full && !pop);
  a_r7_no_pop_empty: assert property (@(posedge clk) disable iff (!rst_n)
    pop |-> !empty);
endmodule

// File: rtl/romwalk_top.sv
module romwalk_top
  import romwalk_pkg::*;
#(
  parameter int DEPTH = 4,
  parameter int MAX_ENTRIES = 960
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        start,
  input  logic [31:0] base_in,
  output logic        busy,
  output logic        done,
  output logic        no_table,
  output logic        stack_err,
  output logic        req_valid,
  input  logic        req_ready,
  output logic [31:0] req_addr,
  input  logic        resp_valid,
  input  logic [31:0] resp_data,
  input  logic        resp_err,
  output logic        rec_valid,
  input  logic        rec_ready,
  output logic [31:0] rec_base,
  output logic [3:0]  rec_class,
  output logic [63:0] rec_pid,
  output logic        rec_id_ok,
  output logic        rec_unreadable
);
  localparam int IDXW = $clog2(MAX_ENTRIES + 1);
  localparam int FW   = 20 + IDXW;
  localparam logic [IDXW-1:0] LAST_IDX = IDXW'(MAX_ENTRIES - 1);
  localparam logic [IDXW-1:0] END_IDX  = IDXW'(MAX_ENTRIES);

  walk_state_t st;
  logic [19:0] tbl_page, comp_page;
  logic [IDXW-1:0] idx;
  logic go_q;

  logic f_req_valid, f_done, f_id_ok, f_err;
  logic [31:0] f_addr;
  logic [63:0] f_pid;
  logic [3:0]  f_cls;

  logic s_push, s_pop, s_empty, s_full;
  logic [FW-1:0] s_top;

  romwalk_idfetch u_fetch (
    .clk(clk), .rst_n(rst_n), .go(go_q), .page(comp_page),
    .req_valid(f_req_valid), .req_ready(req_ready), .req_addr(f_addr),
    .resp_valid(resp_valid), .resp_byte(resp_data[7:0]), .resp_err(resp_err),
    .done(f_done), .pid(f_pid), .cls(f_cls), .id_ok(f_id_ok), .err(f_err)
  );

  romwalk_stack #(.DEPTH(DEPTH), .WIDTH(FW)) u_stack (
    .clk(clk), .rst_n(rst_n), .push(s_push), .pop(s_pop),
    .push_data({tbl_page, idx + IDXW'(1)}), .top_data(s_top),
    .empty(s_empty), .full(s_full)
  );

  logic descend;
  assign descend = rec_id_ok && !rec_unreadable && (rec_class == CLASS_TABLE);
  assign s_push = (st == S_EMIT) && rec_ready && descend && !s_full;
  assign s_pop  = (st == S_POP) && !s_empty;

  assign busy      = (st != S_IDLE);
  assign rec_valid = (st == S_EMIT);
  assign req_valid = f_req_valid || (st == S_ENT_REQ);
  assign req_addr  = (st == S_ENT_REQ) ?
                     {tbl_page, 12'(idx) << 2} : f_addr;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= S_IDLE; tbl_page <= '0; comp_page <= '0; idx <= '0; go_q <= 1'b0;
      done <= 1'b0; no_table <= 1'b0; stack_err <= 1'b0;
      rec_base <= '0; rec_class <= '0; rec_pid <= '0;
      rec_id_ok <= 1'b0; rec_unreadable <= 1'b0;
    end else begin
      go_q <= 1'b0;
      done <= 1'b0;
      case (st)
        S_IDLE: if (start) begin
          no_table <= 1'b0; stack_err <= 1'b0;
          if (base_in[1:0] != 2'b11) begin
            no_table <= 1'b1; st <= S_FINISH;
          end else begin
            tbl_page <= base_in[31:12]; comp_page <= base_in[31:12];
            go_q <= 1'b1; st <= S_ROOT;
          end
        end
        S_ROOT: if (f_done) begin
          if (f_id_ok && !f_err) begin
            idx <= '0; st <= S_ENT_REQ;
          end else begin
            no_table <= 1'b1; st <= S_FINISH;
          end
        end
        S_ENT_REQ: if (req_ready) st <= S_ENT_WAIT;
        S_ENT_WAIT: if (resp_valid) begin
          if (!resp_err && resp_data == 32'd0) begin
            st <= S_POP;
          end else if (!resp_err && entry_present(resp_data)) begin
            comp_page <= tbl_page + resp_data[31:12];
            go_q <= 1'b1; st <= S_COMP;
          end else begin
            idx <= idx + IDXW'(1);
            st  <= (idx == LAST_IDX) ? S_POP : S_ENT_REQ;
          end
        end
        S_COMP: if (f_done) begin
          rec_base <= {comp_page, 12'h000}; rec_class <= f_cls; rec_pid <= f_pid;
          rec_id_ok <= f_id_ok; rec_unreadable <= f_err;
          st <= S_EMIT;
        end
        S_EMIT: if (rec_ready) begin
          if (descend && !s_full) begin
            tbl_page <= comp_page; idx <= '0; st <= S_ENT_REQ;
          end else begin
            if (descend) stack_err <= 1'b1;
            idx <= idx + IDXW'(1);
            st  <= (idx == LAST_IDX) ? S_POP : S_ENT_REQ;
          end
        end
        S_POP: begin
          if (s_empty) st <= S_FINISH;
          else begin
            tbl_page <= s_top[FW-1:IDXW];
            idx <= s_top[IDXW-1:0];
            st  <= (s_top[IDXW-1:0] == END_IDX) ? S_POP : S_ENT_REQ;
          end
        end
        S_FINISH: begin
          done <= 1'b1; st <= S_IDLE;
        end
        default: st <= S_IDLE;
      endcase
    end
  end

  a_r11_rec_hold: assert property (@(posedge clk) disable iff (!rst_n)
    rec_valid && !rec_ready |=> rec_valid && $stable(rec_base) &&
    $stable(rec_pid) && $stable(rec_class) && $stable(rec_unreadable));
  a_r12_req_hold: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && !req_ready |=> req_valid && $stable(req_addr));
  a_r9_idx_bound: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_ENT_REQ) |-> idx < END_IDX);
  a_r13_quiet_idle: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> !req_valid && !rec_valid);
  a_r13_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
endmodule

// File: tb/romwalk_top_tb.sv
`timescale 1ns/1ps
module romwalk_top_tb_top;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start = 1'b0;
  logic [31:0] base_in = '0;
  logic busy, done, no_table, stack_err;
  logic req_valid, req_ready, resp_valid, resp_err;
  logic [31:0] req_addr, resp_data;
  logic rec_valid, rec_ready, rec_id_ok, rec_unreadable;
  logic [31:0] rec_base;
  logic [3:0] rec_class;
  logic [63:0] rec_pid;

  int checks = 0, errors = 0, cyc = 0;
  int rec_cnt = 0, req_cnt = 0, bad_skip = 0, bad_limit = 0;
  logic [31:0] got_base [16];
  logic [3:0]  got_cls  [16];
  logic [63:0] got_pid  [16];
  logic        got_ok   [16];
  logic        got_unr  [16];

  always #4 clk = ~clk;

  romwalk_top dut_i (
    .clk(clk), .rst_n(rst_n), .start(start), .base_in(base_in),
    .busy(busy), .done(done), .no_table(no_table), .stack_err(stack_err),
    .req_valid(req_valid), .req_ready(req_ready), .req_addr(req_addr),
    .resp_valid(resp_valid), .resp_data(resp_data), .resp_err(resp_err),
    .rec_valid(rec_valid), .rec_ready(rec_ready), .rec_base(rec_base),
    .rec_class(rec_class), .rec_pid(rec_pid), .rec_id_ok(rec_id_ok),
    .rec_unreadable(rec_unreadable)
  );

  function automatic logic [32:0] mem_rd(input logic [31:0] a);
    logic [19:0] pg;
    logic [11:0] off;
    int i;
    logic have;
    logic [3:0] cls;
    logic [7:0] c0, p0, p1, p2, p4;
    logic [31:0] d;
    pg = a[31:12]; off = a[11:0]; have = 1'b0; cls = 4'h0;
    c0 = 8'h0D; p0 = 0; p1 = 0; p2 = 0; p4 = 0; d = 0;
    if (pg == 20'h80031) return {1'b1, 32'h0};
    if (pg == 20'h80000 || pg == 20'h80030 || pg == 20'hB0000 ||
        pg[19:4] == 16'hA000) begin have = 1'b1; cls = 4'h1; end
    if (pg == 20'h80010) begin have = 1'b1; cls = 4'h9; p0 = 8'h61; p1 = 8'hB9; p2 = 8'h1B; p4 = 8'h04; end
    if (pg == 20'h8002F) begin have = 1'b1; cls = 4'h9; p0 = 8'h22; end
    if (pg == 20'h80040) begin have = 1'b1; cls = 4'h9; c0 = 8'h0C; end
    if (pg == 20'hB0001) begin have = 1'b1; cls = 4'h9; end
    if (off >= 12'hFD0) begin
      if (!have) return 33'd0;
      i = int'((off - 12'hFD0) >> 2);
      case (i)
        0: d = {24'd0, p4};
        4: d = {24'd0, p0};
        5: d = {24'd0, p1};
        6: d = {24'd0, p2};
        8: d = {24'd0, c0};
        9: d = {24'd0, cls, 4'h0};
        10: d = 32'h05;
        11: d = 32'hB1;
        default: d = 0;
      endcase
      return {1'b0, d};
    end
    i = int'(off >> 2);
    if (pg == 20'h80000) begin
      case (i)
        0: d = 32'h00010003;
        1: d = 32'h00020002;
        2: d = 32'h00030003;
        3: d = 32'h00040003;
        default: d = 0;
      endcase
    end else if (pg == 20'h80030) begin
      if (i == 0) d = 32'hFFFFF003;
      else if (i == 1) d = 32'h00001003;
    end else if (pg[19:4] == 16'hA000) begin
      if (i == 0) d = 32'h00001003;
    end else if (pg == 20'hB0000) begin
      if (i < 959) d = 32'h00000002;
      else if (i == 959) d = 32'h00001003;
      else d = 32'h00002003;
    end
    return {1'b0, d};
  endfunction

  // memory model and monitors (nonblocking, order-safe)
  always @(posedge clk) begin
    cyc <= cyc + 1;
    resp_valid <= req_valid && req_ready && rst_n;
    {resp_err, resp_data} <= mem_rd(req_addr);
    if (req_valid && req_ready) begin
      req_cnt <= req_cnt + 1;
      if (req_addr[31:12] == 20'h80020) bad_skip <= bad_skip + 1;
      if (req_addr[31:12] == 20'hB0000 && req_addr[11:0] >= 12'hF00 &&
          req_addr[11:0] < 12'hFD0) bad_limit <= bad_limit + 1;
      if (req_addr[31:12] == 20'hB0002) bad_limit <= bad_limit + 1;
    end
    if (rec_valid && rec_ready) begin
      if (rec_cnt < 16) begin
        got_base[rec_cnt] <= rec_base; got_cls[rec_cnt] <= rec_class;
        got_pid[rec_cnt] <= rec_pid; got_ok[rec_cnt] <= rec_id_ok;
        got_unr[rec_cnt] <= rec_unreadable;
      end
      rec_cnt <= rec_cnt + 1;
    end
  end

  always @(negedge clk) begin
    req_ready <= (cyc % 4) != 1;
    rec_ready <= (cyc % 3) != 0;
  end

  task automatic check(input logic ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  task automatic run(input logic [31:0] b, input logic poke);
    int n;
    @(negedge clk);
    rec_cnt = 0; req_cnt = 0; bad_skip = 0; bad_limit = 0;
    start = 1'b1; base_in = b;
    @(negedge clk);
    start = 1'b0;
    n = 0;
    while (!done) begin
      @(negedge clk);
      n++;
      if (poke && n == 20) begin start = 1'b1; base_in = 32'h00000002; end
      if (poke && n == 21) start = 1'b0;
      if (n > 20000) begin
        check(1'b0, "watchdog", 64'(n), 64'd0);
        finish_run();
      end
    end
  endtask

  // base, record count, no_table, stack_err
  localparam logic [41:0] VEC [6] = '{
    {32'h80000003, 8'd5, 1'b0, 1'b0},
    {32'h00000002, 8'd0, 1'b1, 1'b0},
    {32'h90000003, 8'd0, 1'b1, 1'b0},
    {32'hA0000003, 8'd5, 1'b0, 1'b1},
    {32'hB0000003, 8'd1, 1'b0, 1'b0},
    {32'h80000001, 8'd0, 1'b1, 1'b0}
  };

  initial begin
    repeat (3) @(negedge clk);
    // reset state (R13)
    check(!busy && !done && !no_table && !stack_err, "R13 reset flags",
          64'({busy, done, no_table, stack_err}), 64'd0);
    check(!req_valid && !rec_valid, "R12 reset idle ports", 64'({req_valid, rec_valid}), 64'd0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);

    for (int v = 0; v < 6; v++) begin
      run(VEC[v][41:10], 1'b0);
      check(rec_cnt == int'(VEC[v][9:2]), $sformatf("R6 R7 record count vec%0d", v),
            64'(rec_cnt), 64'(VEC[v][9:2]));
      check(no_table == VEC[v][1], $sformatf("R1 R2 no_table vec%0d", v),
            64'(no_table), 64'(VEC[v][1]));
      check(stack_err == VEC[v][0], $sformatf("R8 stack_err vec%0d", v),
            64'(stack_err), 64'(VEC[v][0]));
      if (v == 1 || v == 5)
        check(req_cnt == 0, "R1 no read without table", 64'(req_cnt), 64'd0);
      if (v == 3) begin
        check(got_base[3] == 32'hA0004000, "R8 deepest entered", 64'(got_base[3]), 64'hA0004000);
        check(got_base[4] == 32'hA0005000, "R8 overflow record", 64'(got_base[4]), 64'hA0005000);
      end
      if (v == 4) begin
        check(bad_limit == 0, "R9 no read past entry limit", 64'(bad_limit), 64'd0);
        check(got_base[0] == 32'hB0001000, "R9 last allowed entry", 64'(got_base[0]), 64'hB0001000);
      end
    end

    // detailed walk of the nested image (R3 R5 R6 R7 R10)
    run(32'h80000003, 1'b0);
    check(bad_skip == 0, "R4 skipped entry not read", 64'(bad_skip), 64'd0);
    check(got_base[0] == 32'h80010000, "R3 first base", 64'(got_base[0]), 64'h80010000);
    check(got_cls[0] == 4'h9, "R6 class", 64'(got_cls[0]), 64'h9);
    check(got_pid[0] == 64'h00000004_001BB961, "R6 pid order", got_pid[0], 64'h00000004_001BB961);
    check(got_ok[0], "R2 id ok", 64'(got_ok[0]), 64'd1);
    check(got_base[1] == 32'h80030000 && got_cls[1] == 4'h1, "R7 nested record",
          64'(got_base[1]), 64'h80030000);
    check(got_base[2] == 32'h8002F000, "R5 negative offset", 64'(got_base[2]), 64'h8002F000);
    check(got_pid[2] == 64'h22, "R6 nested pid", got_pid[2], 64'h22);
    check(got_base[3] == 32'h80031000 && got_unr[3], "R10 unreadable",
          64'(got_unr[3]), 64'd1);
    check(got_base[4] == 32'h80040000, "R7 parent resumes", 64'(got_base[4]), 64'h80040000);
    check(!got_ok[4] && !got_unr[4], "R2 bad preamble", 64'({got_ok[4], got_unr[4]}), 64'd0);

    // start while busy is ignored (R13)
    run(32'h80000003, 1'b1);
    check(rec_cnt == 5 && !no_table, "R13 start ignored while busy", 64'(rec_cnt), 64'd5);
    @(negedge clk);
    check(!done && !busy, "R13 done is one pulse", 64'({done, busy}), 64'd0);
    check(!no_table, "R13 flag held after walk", 64'(no_table), 64'd0);

    finish_run();
  end

  initial begin
    #1500000;
    check(1'b0, "watchdog global", 64'(cyc), 64'd0);
    finish_run();
  end
endmodule